// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Saturation Flag

This block is a 32-bit arithmetic unit that clamps results instead of wrapping them. An opcode selects one of nine operations. Four are saturating add and subtract, in signed and unsigned forms. One is a plain add that wraps but still records signed overflow. The other four clamp operand `a` into a range of width N. They come in signed and unsigned flavours, and each applies either to the whole word or to each 16-bit half on its own.

Each operation that clamps sets a sticky saturation flag. The flag stays set until the `flag_clr` input is asserted. A datapath can therefore run a long sequence of operations and test the flag once at the end. Operations are accepted on `in_valid`. The result appears one clock later together with `res_valid`. The flag is updated on the same edge as the result.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (signed add) returns a+b. When both operands have the same sign and the sum's sign differs from a, it returns 0x7FFFFFFF for non-negative a or 0x80000000 for negative a, and sets the flag.
- R2: Opcode 1 (signed subtract) returns a-b. When the operands differ in sign and the difference's sign differs from a, it returns the same clamp values as R1 and sets the flag.
- R3: Opcode 2 (unsigned add) returns a+b. If the sum carries out of 32 bits, it returns 0xFFFFFFFF and sets the flag.
- R4: Opcode 3 (unsigned subtract) returns a-b. If b exceeds a, it returns 0 and sets the flag.
- R5: Opcode 4 (recording add) always returns the wrapped 32-bit sum a+b. It sets the flag under the signed-overflow condition of R1.
- R6: Opcode 5 treats a as signed and clamps it to the range -2^s through 2^s-1, where s = `sat_n`. It sets the flag when it clamps.
- R7: Opcode 6 treats a as signed. It returns 0 for negative a, returns 2^s-1 for a above 2^s-1, and otherwise returns a. It sets the flag when it clamps.
- R8: Opcode 7 splits a into bits [31:16] and [15:0]. It treats each half as a signed 16-bit value, clamps each one as in R6, and places the two results back in their own lanes. The flag is set if either half clamps.
- R9: Opcode 8 splits a into bits [31:16] and [15:0]. It treats each half as a signed 16-bit value, clamps each one as in R7, and places the two results back in their own lanes. The flag is set if either half clamps.
- R10: The flag is never cleared by an operation. It is cleared by `flag_clr`. If a clamping operation and `flag_clr` occur in the same cycle, the flag ends up set.
- R11: `res` and `res_valid` are updated one clock after `in_valid`. While `in_valid` is low, `res` holds its value and the flag changes only through `flag_clr`.
- R12: After reset, `res` is 0, `res_valid` is 0 and the flag is 0.
- R13: Opcodes 9 to 15 return 0 and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op | input | 4 | Operation select |
| a | input | 32 | First operand; the value to clamp for saturate operations |
| b | input | 32 | Second operand for add and subtract |
| sat_n | input | 5 | Clamp width s for saturate operations |
| flag_clr | input | 1 | Clears the sticky flag |
| res | output | 32 | Registered result |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
The properties assume that `op`, `a`, `b` and `sat_n` are valid only in cycles where `in_valid` is high. They also assume that `flag_clr` may arrive in any cycle, including one that carries a clamping operation. The stimulus changes every input only at the falling edge. It keeps `in_valid` high for exactly one cycle per operation, and it places idle cycles between operations so that the hold behaviour is exercised. The vector table asserts `flag_clr` together with each operation, so that the flag afterwards reflects only that operation. The directed tests then leave `flag_clr` low to show that the flag persists.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

    // Operation codes seen on the op port
    typedef enum logic [3:0] {
        OP_SADD  = 4'd0,
        OP_SSUB  = 4'd1,
        OP_UADD  = 4'd2,
        OP_USUB  = 4'd3,
        OP_ADDQ  = 4'd4,
        OP_SSATW = 4'd5,
        OP_USATW = 4'd6,
        OP_SSATH = 4'd7,
        OP_USATH = 4'd8
    } sat_op_e;

    // Mode of the add/subtract datapath
    typedef enum logic [2:0] {
        AS_SADD = 3'd0,
        AS_SSUB = 3'd1,
        AS_UADD = 3'd2,
        AS_USUB = 3'd3,
        AS_ADDQ = 3'd4
    } as_mode_e;

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  as_mode_e     mode,
    output logic [W-1:0] sum_o,
    output logic         hit_o
);

    logic [W:0]   wide_sum;
    logic [W-1:0] diff;
    logic [W-1:0] s_limit;
    logic         s_ovf_add;
    logic         s_ovf_sub;

    always_comb begin
        wide_sum  = {1'b0, a} + {1'b0, b};
        diff      = a - b;
        s_ovf_add = (wide_sum[W-1] ^ a[W-1]) & ~(a[W-1] ^ b[W-1]);
        s_ovf_sub = (diff[W-1] ^ a[W-1]) & (a[W-1] ^ b[W-1]);
        // most positive for non-negative a, most negative otherwise
        s_limit   = {a[W-1], {(W-1){~a[W-1]}}};

        sum_o = wide_sum[W-1:0];
        hit_o = 1'b0;
        case (mode)
            AS_SADD: begin
                hit_o = s_ovf_add;
                sum_o = s_ovf_add ? s_limit : wide_sum[W-1:0];
            end
            AS_SSUB: begin
                hit_o = s_ovf_sub;
                sum_o = s_ovf_sub ? s_limit : diff;
            end
            AS_UADD: begin
                hit_o = wide_sum[W];
                sum_o = wide_sum[W] ? '1 : wide_sum[W-1:0];
            end
            AS_USUB: begin
                hit_o = (b > a);
                sum_o = (b > a) ? '0 : diff;
            end
            AS_ADDQ: begin
                hit_o = s_ovf_add;
                sum_o = wide_sum[W-1:0];
            end
            default: begin
                hit_o = 1'b0;
                sum_o = wide_sum[W-1:0];
            end
        endcase
    end

endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W    = 32,
    parameter int SH_W = 5
) (
    input  logic [W-1:0]    val,
    input  logic [SH_W-1:0] sh,
    input  logic            uns,
    output logic [W-1:0]    res_o,
    output logic            hit_o
);

    logic [W:0]          mask_wide;
    logic [W-1:0]        mask;
    logic signed [W-1:0] top;
    logic                top_pos;
    logic                top_low;

    always_comb begin
        // shifts at or beyond W+1 wrap to all ones, which never clamps
        mask_wide = ({{W{1'b0}}, 1'b1} << sh) - 1'b1;
        mask      = mask_wide[W-1:0];
        top       = $signed(val) >>> sh;
        top_pos   = ~top[W-1] & (|top);
        top_low   = top[W-1] & ~(&top);

        res_o = val;
        hit_o = 1'b0;
        if (uns) begin
            if (val[W-1]) begin
                res_o = '0;
                hit_o = 1'b1;
            end else if (val > mask) begin
                res_o = mask;
                hit_o = 1'b1;
            end
        end else begin
            if (top_pos) begin
                res_o = mask;
                hit_o = 1'b1;
            end else if (top_low) begin
                res_o = ~mask;
                hit_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [3:0]                  op,
    input  logic [DATA_W-1:0]           a,
    input  logic [DATA_W-1:0]           b,
    input  logic [$clog2(DATA_W)-1:0]   sat_n,
    input  logic                        flag_clr,
    output logic [DATA_W-1:0]           res,
    output logic                        res_valid,
    output logic                        sat_flag
);

    localparam int SH_W   = $clog2(DATA_W);
    localparam int LANES  = 2;
    localparam int HALF_W = DATA_W / LANES;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              vld;
        logic              flag;
    } state_t;

    state_t st_d, st_q;

    as_mode_e          as_mode;
    logic [DATA_W-1:0] as_res;
    logic              as_hit;
    logic [DATA_W-1:0] word_res;
    logic              word_hit;
    logic [DATA_W-1:0] half_res;
    logic [LANES-1:0]  half_hit;

    always_comb begin
        case (op)
            OP_SADD: as_mode = AS_SADD;
            OP_SSUB: as_mode = AS_SSUB;
            OP_UADD: as_mode = AS_UADD;
            OP_USUB: as_mode = AS_USUB;
            default: as_mode = AS_ADDQ;
        endcase
    end

    sat_addsub #(.W(DATA_W)) u_addsub (
        .a     (a),
        .b     (b),
        .mode  (as_mode),
        .sum_o (as_res),
        .hit_o (as_hit)
    );

    sat_clamp #(.W(DATA_W), .SH_W(SH_W)) u_word (
        .val   (a),
        .sh    (sat_n),
        .uns   (op == OP_USATW),
        .res_o (word_res),
        .hit_o (word_hit)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sat_clamp #(.W(HALF_W), .SH_W(SH_W)) u_half (
            .val   (a[i*HALF_W +: HALF_W]),
            .sh    (sat_n),
            .uns   (op == OP_USATH),
            .res_o (half_res[i*HALF_W +: HALF_W]),
            .hit_o (half_hit[i])
        );
    end

    always_comb begin
        logic              hit;
        logic [DATA_W-1:0] nres;
        hit  = 1'b0;
        nres = '0;
        case (op)
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_ADDQ: begin
                nres = as_res;
                hit  = as_hit;
            end
            OP_SSATW, OP_USATW: begin
                nres = word_res;
                hit  = word_hit;
            end
            OP_SSATH, OP_USATH: begin
                nres = half_res;
                hit  = |half_hit;
            end
            default: begin
                nres = '0;
                hit  = 1'b0;
            end
        endcase

        st_d      = st_q;
        st_d.vld  = in_valid;
        if (in_valid) begin
            st_d.res = nres;
        end
        st_d.flag = (st_q.flag & ~flag_clr) | (in_valid & hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res       = st_q.res;
    assign res_valid = st_q.vld;
    assign sat_flag  = st_q.flag;

endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic [3:0]                op,
    input logic [DATA_W-1:0]         a,
    input logic [$clog2(DATA_W)-1:0] sat_n,
    input logic                      flag_clr,
    input logic [DATA_W-1:0]         res,
    input logic                      res_valid,
    input logic                      sat_flag
);

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_flag && !flag_clr) |=> sat_flag);

    // R10
    flag_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sat_flag && !in_valid) |=> !sat_flag);

    // R11
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);

    // R11
    vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !res_valid);

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(res));

    // R3
    uadd_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd2) |=> (res >= $past(a)));

    // R4
    usub_ceil_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd3) |=> (res <= $past(a)));

    // R7
    usat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == 4'd6) |=> ((res >> $past(sat_n)) == '0));

    // R13
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op > 4'd8) |=> (res == '0));

endmodule

bind sat_alu sat_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .a         (a),
    .sat_n     (sat_n),
    .flag_clr  (flag_clr),
    .res       (res),
    .res_valid (res_valid),
    .sat_flag  (sat_flag)
);

// File: tb/sat_alu_bench.sv
module sat_alu_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op = '0;
    logic [31:0] a = '0;
    logic [31:0] b = '0;
    logic [4:0]  sat_n = '0;
    logic        flag_clr = 1'b0;
    logic [31:0] res;
    logic        res_valid;
    logic        sat_flag;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    sat_alu u_sat_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .a         (a),
        .b         (b),
        .sat_n     (sat_n),
        .flag_clr  (flag_clr),
        .res       (res),
        .res_valid (res_valid),
        .sat_flag  (sat_flag)
    );

    // {op, s, a, b, expected result, expected flag}
    localparam int NV = 31;
    localparam logic [105:0] VEC [NV] = '{
        {4'd0, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFF, 1'b1},
        {4'd0, 5'd0,  32'h80000000, 32'hFFFFFFFF, 32'h80000000, 1'b1},
        {4'd0, 5'd0,  32'h00000005, 32'h00000003, 32'h00000008, 1'b0},
        {4'd1, 5'd0,  32'h80000000, 32'h00000001, 32'h80000000, 1'b1},
        {4'd1, 5'd0,  32'h7FFFFFFF, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b1},
        {4'd1, 5'd0,  32'h0000000A, 32'h00000003, 32'h00000007, 1'b0},
        {4'd2, 5'd0,  32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFF, 1'b1},
        {4'd2, 5'd0,  32'h00000001, 32'h00000002, 32'h00000003, 1'b0},
        {4'd3, 5'd0,  32'h00000001, 32'h00000002, 32'h00000000, 1'b1},
        {4'd3, 5'd0,  32'h00000005, 32'h00000005, 32'h00000000, 1'b0},
        {4'd4, 5'd0,  32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1},
        {4'd4, 5'd0,  32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0},
        {4'd5, 5'd7,  32'h000000C8, 32'h0,        32'h0000007F, 1'b1},
        {4'd5, 5'd7,  32'hFFFFFF38, 32'h0,        32'hFFFFFF80, 1'b1},
        {4'd5, 5'd7,  32'hFFFFFF80, 32'h0,        32'hFFFFFF80, 1'b0},
        {4'd5, 5'd31, 32'h80000000, 32'h0,        32'h80000000, 1'b0},
        {4'd5, 5'd0,  32'h00000001, 32'h0,        32'h00000000, 1'b1},
        {4'd5, 5'd0,  32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 1'b0},
        {4'd6, 5'd8,  32'h0000012C, 32'h0,        32'h000000FF, 1'b1},
        {4'd6, 5'd8,  32'hFFFFFFFF, 32'h0,        32'h00000000, 1'b1},
        {4'd6, 5'd8,  32'h000000FF, 32'h0,        32'h000000FF, 1'b0},
        {4'd6, 5'd31, 32'h80000000, 32'h0,        32'h00000000, 1'b1},
        {4'd6, 5'd0,  32'h00000001, 32'h0,        32'h00000000, 1'b1},
        {4'd7, 5'd7,  32'h0100FF00, 32'h0,        32'h007FFF80, 1'b1},
        {4'd7, 5'd15, 32'h80007FFF, 32'h0,        32'h80007FFF, 1'b0},
        {4'd7, 5'd3,  32'h00050002, 32'h0,        32'h00050002, 1'b0},
        {4'd7, 5'd3,  32'h00090001, 32'h0,        32'h00070001, 1'b1},
        {4'd8, 5'd8,  32'h01238000, 32'h0,        32'h00FF0000, 1'b1},
        {4'd8, 5'd16, 32'h7FFFFFFF, 32'h0,        32'h7FFF0000, 1'b1},
        {4'd8, 5'd4,  32'h000A0003, 32'h0,        32'h000A0003, 1'b0},
        {4'd15, 5'd0, 32'h0000007B, 32'h00000001, 32'h00000000, 1'b0}
    };

    function automatic string tag_of(input logic [3:0] code);
        case (code)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7: return "R8";
            4'd8: return "R9";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // one valid cycle, sampled at the following falling edge
    task automatic run_op(input logic [3:0] o, input logic [4:0] s,
                          input logic [31:0] va, input logic [31:0] vb,
                          input logic clr);
        @(negedge clk);
        op = o; sat_n = s; a = va; b = vb; flag_clr = clr; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        flag_clr = 1'b0;
    endtask

    task automatic idle(input logic clr);
        @(negedge clk);
        a = 32'hDEADBEEF; b = 32'h12345678; op = 4'd0; flag_clr = clr;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        check("R12", "res",       res, 32'h0);
        check("R12", "res_valid", {31'b0, res_valid}, 32'h0);
        check("R12", "flag",      {31'b0, sat_flag}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: clear asserted with each op, so flag shows this op only
        for (int i = 0; i < NV; i++) begin
            run_op(VEC[i][105:102], VEC[i][101:97], VEC[i][96:65], VEC[i][64:33], 1'b1);
            check(tag_of(VEC[i][105:102]), "res",  res, VEC[i][32:1]);
            check(tag_of(VEC[i][105:102]), "flag", {31'b0, sat_flag}, {31'b0, VEC[i][0]});
            check("R11", "res_valid", {31'b0, res_valid}, 32'h1);
        end

        // R10: flag persists across a non-clamping op without clear
        run_op(4'd2, 5'd0, 32'hFFFFFFFF, 32'h1, 1'b1);
        run_op(4'd2, 5'd0, 32'h1, 32'h1, 1'b0);
        check("R10", "res after clean op", res, 32'h2);
        check("R10", "flag kept", {31'b0, sat_flag}, 32'h1);

        // R11: idle cycles hold result and drop res_valid
        idle(1'b0);
        check("R11", "res held", res, 32'h2);
        check("R11", "res_valid low", {31'b0, res_valid}, 32'h0);
        check("R10", "flag kept idle", {31'b0, sat_flag}, 32'h1);

        // R13: unused opcode leaves flag set
        run_op(4'd9, 5'd0, 32'h7FFFFFFF, 32'h1, 1'b0);
        check("R13", "res zero", res, 32'h0);
        check("R13", "flag untouched", {31'b0, sat_flag}, 32'h1);

        // R10: explicit clear alone
        idle(1'b1);
        check("R10", "flag cleared", {31'b0, sat_flag}, 32'h0);

        // R13: unused opcode with flag clear does not set it
        run_op(4'd12, 5'd3, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
        check("R13", "flag stays clear", {31'b0, sat_flag}, 32'h0);

        // R5: recording add sets flag without clamping, no clear
        run_op(4'd4, 5'd0, 32'h80000000, 32'h80000000, 1'b0);
        check("R5", "wrapped sum", res, 32'h0);
        check("R5", "flag set", {31'b0, sat_flag}, 32'h1);

        // R10: clamp and clear in the same cycle -> set
        idle(1'b1);
        run_op(4'd3, 5'd0, 32'h0, 32'h1, 1'b1);
        check("R10", "clamp beats clear", {31'b0, sat_flag}, 32'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule